// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked system use an external asynchronous static RAM of 131,072 bytes. The host raises a request together with an address, a direction flag and write data. It holds them until a one-cycle acknowledge comes back, and a read returns its byte on a registered output in that same cycle. On the memory side the block drives the address lines, the active-low chip, write and output enables, an output byte and an enable for the data pad's tristate driver. It also takes in the byte that the memory puts on the bus.

Every phase of an access lasts a whole number of clock cycles. That number is derived when the block is elaborated: the memory's nanosecond limit is divided by the clock period, rounded up, and never taken below one. All memory-side outputs come directly from flip-flops. After a read, the block waits long enough for the memory to release the bus before its own data driver turns on.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is applied and after it is released, the chip, write and output enables are high, the data driver enable and the acknowledge are low.
- R2: Encodings: a write drives chip enable low, write enable low and output enable high. A read drives chip enable low, write enable high and output enable low. The data driver is never on while output enable is low.
- R3: For a write, the address, the data, the driver enable and a low chip enable are in place one cycle before write enable falls. Address and data do not change while write enable is low, nor in the first cycle after it rises.
- R4: A write keeps chip enable low for 1 + P + H cycles, where P is the write-enable low time and H = max(1, ceil(tWC/Tclk) - 1 - P). Its acknowledge appears P + H + 2 rising edges after the request is raised in an idle cycle.
- R5: A read holds output enable low for R = max(ceil(tAA/Tclk), ceil(tOE/Tclk)) cycles and captures the bus at the edge that ends the last of them. The captured byte appears on rd_data in the acknowledge cycle, 1 + R edges after the request.
- R6: Once output enable rises at the end of a read, the data driver stays off for ceil(tOHZ/Tclk) cycles. A write that directly follows a read waits out that window.
- R7: Acknowledge is high for exactly one cycle. A request is not accepted in the cycle in which acknowledge is high, so a request that is held straight on starts one cycle later.
- R8: P equals the largest of ceil(tWP/Tclk), ceil(tDW/Tclk), ceil(tAW/Tclk) and ceil(tCW/Tclk). Each ceiling is taken as at least one cycle.
- R9: A byte written to any address reads back unchanged, and writes to other addresses leave it untouched.
- R10: In the acknowledge cycle and whenever no access is in progress, chip enable is high, which puts the memory in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Registered read byte |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Byte driven towards the memory |
| mem_dq_oe | output | 1 | Enable for the pad's data driver |
| mem_dq_i | input | DATA_W | Byte read from the memory bus |

## Verification
The hardest case to reach is a write that follows a read with no idle cycle between them, while the memory model is still treated as driving the bus during its release window. The bench creates it by raising a write request in the very cycle the read acknowledge is seen. Its memory model counts release cycles after output enable rises and reports contention if the driver turns on too early. The same model returns the inverted byte until the read access time, in cycles, has elapsed, so an access cut short shows up as wrong data.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 8000,
  parameter int T_AA_PS   = 10000,
  parameter int T_OE_PS   = 5000,
  parameter int T_WC_PS   = 10000,
  parameter int T_WP_PS   = 7000,
  parameter int T_AW_PS   = 8000,
  parameter int T_CW_PS   = 8000,
  parameter int T_DW_PS   = 5000,
  parameter int T_OHZ_PS  = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RD = imax(cyc(T_AA_PS), cyc(T_OE_PS));
  localparam int N_WP = imax(imax(cyc(T_WP_PS), cyc(T_DW_PS)),
                             imax(cyc(T_AW_PS), cyc(T_CW_PS)));
  localparam int N_WH = imax(1, cyc(T_WC_PS) - 1 - N_WP);
  localparam int N_TA = cyc(T_OHZ_PS);
  localparam int N_MAX = imax(imax(N_RD, N_WP), imax(N_WH, N_TA));
  localparam int CW = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WPUL, S_WHLD, S_RACC} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   rel;
  logic            cnt_done;

  assign cnt_done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      rel       <= '0;
      ack       <= 1'b0;
      rd_data   <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (rel != '0) rel <= rel - 1'b1;
      case (state)
        S_IDLE: begin
          if (req && !ack) begin
            if (!req_wr) begin
              mem_addr <= req_addr;
              mem_ce_n <= 1'b0;
              mem_oe_n <= 1'b0;
              cnt      <= CW'(N_RD - 1);
              state    <= S_RACC;
            end else if (rel == '0) begin
              mem_addr  <= req_addr;
              mem_dq_o  <= req_wdata;
              mem_ce_n  <= 1'b0;
              mem_dq_oe <= 1'b1;
              state     <= S_WSET;
            end
          end
        end
        S_WSET: begin
          mem_we_n <= 1'b0;
          cnt      <= CW'(N_WP - 1);
          state    <= S_WPUL;
        end
        S_WPUL: begin
          if (cnt_done) begin
            mem_we_n <= 1'b1;
            cnt      <= CW'(N_WH - 1);
            state    <= S_WHLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WHLD: begin
          if (cnt_done) begin
            mem_ce_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            ack       <= 1'b1;
            state     <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RACC: begin
          if (cnt_done) begin
            rd_data  <= mem_dq_i;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            ack      <= 1'b1;
            rel      <= CW'(N_TA - 1);
            state    <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n && mem_oe_n && mem_dq_oe); // R2

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R2

  AST_WRITE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_ce_n) && $past(mem_dq_oe) &&
                        $stable(mem_addr) && $stable(mem_dq_o)); // R3

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> $stable(mem_addr) && $stable(mem_dq_o) && !mem_ce_n); // R3

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> !mem_dq_oe); // R6

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R7

  AST_ACK_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe); // R10

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int TCLK = 8000, TAA = 20000, TOE = 5000, TWC = 40000, TWP = 15000;
  localparam int TAWS = 8000, TCW = 8000, TDW = 5000, TOHZ = 20000;

  function automatic int cy(input int ps);
    int c;
    c = (ps + TCLK - 1) / TCLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD  = mx(cy(TAA), cy(TOE));
  localparam int E_WP  = mx(mx(cy(TWP), cy(TDW)), mx(cy(TAWS), cy(TCW)));
  localparam int E_WH  = mx(1, cy(TWC) - 1 - E_WP);
  localparam int E_TA  = cy(TOHZ);
  localparam int W_LAT = 2 + E_WP + E_WH;
  localparam int R_LAT = 1 + E_RD;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_wr = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ack;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] mem [DEPTH];
  int rd_age = 0, rel = 0, wl_cnt = 0, ce_cnt = 0;
  logic span_wr = 0, we_prev = 1, ce_prev = 1, oe_prev = 1, dq_oe_prev = 0;
  logic [AW-1:0] addr_prev = '0, wl_addr = '0, rd_addr = '0;
  logic [DW-1:0] dat_prev = '0, wl_dat = '0;
  logic rd_cond;

  always #4 clk = ~clk;

  sram_async_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PS(TCLK), .T_AA_PS(TAA), .T_OE_PS(TOE),
    .T_WC_PS(TWC), .T_WP_PS(TWP), .T_AW_PS(TAWS), .T_CW_PS(TCW),
    .T_DW_PS(TDW), .T_OHZ_PS(TOHZ)
  ) u_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  assign rd_cond  = !mem_ce_n && mem_we_n && !mem_oe_n;
  assign mem_dq_i = rd_cond ? ((rd_age >= E_RD) ? mem[mem_addr] : ~mem[mem_addr]) : '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && (rd_cond || rel > 0))
        chk(0, "R6 contention", rel, 0);
      if (!mem_we_n) begin
        chk(!mem_ce_n && mem_oe_n, "R2 write encoding", {mem_ce_n, mem_oe_n}, 1);
        if (we_prev) begin
          chk(!ce_prev && dq_oe_prev && mem_addr == addr_prev && mem_dq_o == dat_prev,
              "R3 setup", mem_addr, addr_prev);
          wl_addr = mem_addr; wl_dat = mem_dq_o; wl_cnt = 1;
        end else begin
          wl_cnt++;
          if (mem_addr != wl_addr || mem_dq_o != wl_dat || !mem_dq_oe)
            chk(0, "R3 stable during pulse", mem_dq_o, wl_dat);
        end
        span_wr = 1;
      end else if (!we_prev) begin
        chk(wl_cnt == E_WP, "R8 write pulse cycles", wl_cnt, E_WP);
        chk(mem_addr == wl_addr && mem_dq_o == wl_dat && !mem_ce_n,
            "R3 hold", mem_dq_o, wl_dat);
        mem[wl_addr] = wl_dat;
      end
      if (!mem_oe_n)
        chk(!mem_ce_n && mem_we_n, "R2 read encoding", {mem_ce_n, mem_we_n}, 1);
      if (!mem_ce_n) ce_cnt++;
      else if (ce_cnt != 0) begin
        if (span_wr) chk(ce_cnt == 1 + E_WP + E_WH, "R4 write cycle span", ce_cnt, 1 + E_WP + E_WH);
        else         chk(ce_cnt == E_RD, "R5 read span", ce_cnt, E_RD);
        ce_cnt = 0; span_wr = 0;
      end
      if (rd_cond) rd_age = (rd_age > 0 && mem_addr == rd_addr) ? rd_age + 1 : 1;
      else rd_age = 0;
      rd_addr = mem_addr;
      if (rd_cond) rel = E_TA;
      else if (rel > 0) rel--;
      we_prev = mem_we_n; ce_prev = mem_ce_n; oe_prev = mem_oe_n;
      dq_oe_prev = mem_dq_oe; addr_prev = mem_addr; dat_prev = mem_dq_o;
    end
  end

  task automatic access(input bit wr, input int a, input int d, output int lat, output int rd);
    req = 1; req_wr = wr; req_addr = AW'(a); req_wdata = DW'(d);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!ack && lat < 100);
    rd = int'(rd_data);
    chk(mem_ce_n, "R10 standby at ack", mem_ce_n, 1);
    req = 0;
  endtask

  task automatic gap();
    @(negedge clk);
    chk(!ack, "R7 ack single cycle", ack, 0);
  endtask

  function automatic int pat(input int a, input int s);
    return (a * 37 + s * 11 + 5) & 8'hFF;
  endfunction

  initial begin
    int lat, rd;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !ack, "R1 in reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, ack}, 5'b11100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !ack, "R1 after reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, ack}, 5'b11100);

    for (int a = 0; a < DEPTH; a++) begin
      access(1, a, pat(a, 0), lat, rd);
      chk(lat == W_LAT, "R4 write latency", lat, W_LAT);
      gap();
    end
    for (int a = 0; a < DEPTH; a++) begin
      access(0, a, 0, lat, rd);
      chk(lat == R_LAT, "R5 read latency", lat, R_LAT);
      chk(rd == pat(a, 0), "R9 readback", rd, pat(a, 0));
      gap();
    end

    for (int a = 0; a < DEPTH; a += 3) begin
      access(0, a, 0, lat, rd);
      chk(rd == pat(a, 0), "R9 read before overwrite", rd, pat(a, 0));
      access(1, a, pat(a, 1), lat, rd);
      chk(lat == mx(1, E_TA - 1) + W_LAT, "R6 read-to-write latency", lat, mx(1, E_TA - 1) + W_LAT);
      access(0, a, 0, lat, rd);
      chk(lat == R_LAT + 1, "R7 held request waits one cycle", lat, R_LAT + 1);
      chk(rd == pat(a, 1), "R9 overwrite", rd, pat(a, 1));
      gap();
    end

    for (int a = 1; a < DEPTH; a += 5) begin
      access(1, a, pat(a, 2), lat, rd);
      access(1, a - 1, pat(a, 3), lat, rd);
      chk(lat == W_LAT + 1, "R7 write after write", lat, W_LAT + 1);
      gap();
    end
    for (int a = 0; a < DEPTH; a++) begin
      int e;
      e = ((a % 5) == 1) ? pat(a, 2) : ((a % 5) == 0 && a + 1 < DEPTH) ? pat(a + 1, 3)
          : ((a % 3) == 0) ? pat(a, 1) : pat(a, 0);
      access(0, a, 0, lat, rd);
      chk(rd == e, "R9 final sweep", rd, e);
      gap();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule